// File: doc/BRIEF.md
# Bit-Field Extract and Byte-Align Unit

This unit performs one of three bit-manipulation operations on two data operands and registers the outcome. It pulls a contiguous bit field out of the first operand and right-justifies it. It mirrors the bit order inside every byte of the second operand. It also builds a word from the two operands joined at a byte boundary. A 2-bit operation code picks the operation. Two position fields describe the extract: the starting bit and the width minus one. A byte-count field selects the joint for the align.

Results appear one clock after an accepted request. Each result carries a valid flag, an unsupported-operation flag and a hint that tells the surrounding pipeline which destination class the result belongs to. Field results go to the "field" destination. Byte-shuffle results (bit mirror and align) go to the "shuffle" destination. The data width is a parameter that must be a whole number of bytes. The align datapath comes in two interchangeable implementations, chosen by a parameter.

Top module: `fxu_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_vld`, `out_illegal`, `out_to_rd` and `out_data` are all zero after that edge.
- R2: With `op`=2'b00 (extract), the result is bits `lsb_pos` upward of `src_a`, `size_m1`+1 bits wide, placed at bit 0, with every bit above the field equal to zero.
- R3: For an extract where `lsb_pos`+`size_m1`+1 exceeds the data width, the field positions beyond the top of `src_a` read as zero.
- R4: With `op`=2'b01 (bit mirror), result bit 8k+j equals `src_b` bit 8k+7-j for every byte k and bit j in 0..7.
- R5: With `op`=2'b10 (align) and `byte_pos`=0, the result equals `src_b`.
- R6: With `op`=2'b10 and `byte_pos`=p>0, the result is `src_b` shifted left by 8p bits ORed with `src_a` shifted right by 8(N-p) bits, where N is the number of bytes in a word.
- R7: With `op`=2'b11 (unsupported), `out_illegal` is 1 and `out_data` is zero.
- R8: `out_vld` equals the `in_vld` sampled at the previous edge. When `in_vld` is 0, `out_data`, `out_illegal` and `out_to_rd` keep their previous values.
- R9: `out_to_rd` is 1 for the bit mirror and align operations, and 0 for extract and unsupported codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request valid |
| op | input | 2 | Operation: 00 extract, 01 bit mirror, 10 align, 11 unsupported |
| src_a | input | DATA_W | First operand (extract source, low part of align) |
| src_b | input | DATA_W | Second operand (mirror source, high part of align) |
| lsb_pos | input | clog2(DATA_W) | Extract start bit |
| size_m1 | input | clog2(DATA_W) | Extract width minus one |
| byte_pos | input | clog2(DATA_W/8) | Align byte count |
| out_vld | output | 1 | Result valid |
| out_data | output | DATA_W | Result |
| out_illegal | output | 1 | Unsupported operation flag |
| out_to_rd | output | 1 | Result belongs to the shuffle destination |

## Verification
The bench builds the unit at its default 32-bit width with the shift/OR align variant. That width keeps the extract space small enough to sweep every start position against every field size, for two operand patterns, which covers all overflow cases of R3. Every byte value is pushed through the mirror, and every byte position of the align is tried with several operand pairs. The illegal code and idle cycles are interleaved to check flag and hold behaviour.

// File: rtl/fxu_pkg.sv
package fxu_pkg;
   typedef enum logic [1:0] {
      FXU_EXTRACT = 2'b00,
      FXU_BITREV  = 2'b01,
      FXU_ALIGN   = 2'b10,
      FXU_RSVD    = 2'b11
   } fxu_op_e;
endpackage

// File: rtl/fxu_extract.sv
module fxu_extract #(
   parameter int DATA_W = 32,
   localparam int POS_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] src,
   input  logic [POS_W-1:0]  lsb,
   input  logic [POS_W-1:0]  len_m1,
   output logic [DATA_W-1:0] field
);
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] mask;

   // Logical right shift brings the field down; vacated bits are zero.
   assign shifted = src >> lsb;

   // Thermometer mask: bit i is kept when i is inside the field length.
   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign mask[i] = (POS_W'(i) <= len_m1);
   end

   assign field = shifted & mask;

   // R2: nothing survives above the field length.
   always_comb begin
      if (int'(len_m1) < DATA_W - 1)
         a_r2_no_upper: assert ((field >> (int'(len_m1) + 1)) == '0)
            else $error("extract leaked bits above field length");
   end

   // R3: positions beyond the source top read as zero.
   always_comb begin
      if (int'(lsb) + int'(len_m1) + 1 > DATA_W)
         a_r3_zero_fill: assert ((field >> (DATA_W - int'(lsb))) == '0)
            else $error("extract did not zero fill past source top");
   end
endmodule

// File: rtl/fxu_bitrev.sv
module fxu_bitrev #(
   parameter int DATA_W = 32,
   localparam int NB = DATA_W / 8
) (
   input  logic [DATA_W-1:0] src,
   output logic [DATA_W-1:0] mirrored
);
   for (genvar k = 0; k < NB; k++) begin : g_byte
      for (genvar j = 0; j < 8; j++) begin : g_bit
         assign mirrored[8*k + j] = src[8*k + 7 - j];
      end
   end
endmodule

// File: rtl/fxu_align.sv
module fxu_align #(
   parameter int DATA_W     = 32,
   parameter bit FUNNEL_IMPL = 1'b0,
   localparam int NB   = DATA_W / 8,
   localparam int BP_W = $clog2(NB),
   localparam int SH_W = $clog2(DATA_W) + 1
) (
   input  logic [DATA_W-1:0] lo_src,
   input  logic [DATA_W-1:0] hi_src,
   input  logic [BP_W-1:0]   bp,
   output logic [DATA_W-1:0] joined
);
   logic [SH_W-1:0] sh_up;
   logic [SH_W-1:0] sh_dn;

   assign sh_up = SH_W'(int'(bp) * 8);
   assign sh_dn = SH_W'((NB - int'(bp)) * 8);

   if (FUNNEL_IMPL) begin : g_funnel
      // One wide shifter over the concatenation; bp=0 shifts by a full word.
      logic [2*DATA_W-1:0] pair;
      logic [2*DATA_W-1:0] pair_sh;
      assign pair    = {hi_src, lo_src};
      assign pair_sh = pair >> sh_dn;
      assign joined  = pair_sh[DATA_W-1:0];
   end else begin : g_shift_or
      // Two word-wide shifters plus a bypass for the zero position.
      logic [DATA_W-1:0] up_part;
      logic [DATA_W-1:0] dn_part;
      assign up_part = hi_src << sh_up;
      assign dn_part = lo_src >> sh_dn;
      assign joined  = (bp == '0) ? hi_src : (up_part | dn_part);
   end

   // R5: a zero byte position passes the high operand through.
   always_comb begin
      if (bp == '0)
         a_r5_passthru: assert (joined == hi_src)
            else $error("align with zero position altered operand");
   end
endmodule

// File: rtl/fxu_unit.sv
module fxu_unit #(
   parameter int DATA_W      = 32,
   parameter bit FUNNEL_IMPL = 1'b0,
   localparam int POS_W = $clog2(DATA_W),
   localparam int NB    = DATA_W / 8,
   localparam int BP_W  = $clog2(NB)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [POS_W-1:0]  lsb_pos,
   input  logic [POS_W-1:0]  size_m1,
   input  logic [BP_W-1:0]   byte_pos,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_data,
   output logic              out_illegal,
   output logic              out_to_rd
);
   import fxu_pkg::*;

   if (DATA_W % 8 != 0) begin : g_bad_bytes
      $error("DATA_W must be a whole number of bytes");
   end
   if (NB < 2 || (NB & (NB - 1)) != 0) begin : g_bad_nb
      $error("DATA_W/8 must be a power of two of at least 2");
   end

   logic [DATA_W-1:0] ext_res;
   logic [DATA_W-1:0] rev_res;
   logic [DATA_W-1:0] aln_res;
   logic [DATA_W-1:0] sel_res;
   logic              sel_bad;
   logic              sel_rd;
   fxu_op_e           op_e;

   assign op_e = fxu_op_e'(op);

   fxu_extract #(.DATA_W(DATA_W)) u_extract (
      .src(src_a), .lsb(lsb_pos), .len_m1(size_m1), .field(ext_res)
   );

   fxu_bitrev #(.DATA_W(DATA_W)) u_bitrev (
      .src(src_b), .mirrored(rev_res)
   );

   fxu_align #(.DATA_W(DATA_W), .FUNNEL_IMPL(FUNNEL_IMPL)) u_align (
      .lo_src(src_a), .hi_src(src_b), .bp(byte_pos), .joined(aln_res)
   );

   always_comb begin
      sel_res = '0;
      sel_bad = 1'b0;
      sel_rd  = 1'b0;
      unique case (op_e)
         FXU_EXTRACT: sel_res = ext_res;
         FXU_BITREV:  begin sel_res = rev_res; sel_rd = 1'b1; end
         FXU_ALIGN:   begin sel_res = aln_res; sel_rd = 1'b1; end
         default:     sel_bad = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld     <= 1'b0;
         out_data    <= '0;
         out_illegal <= 1'b0;
         out_to_rd   <= 1'b0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_data    <= sel_res;
            out_illegal <= sel_bad;
            out_to_rd   <= sel_rd;
         end
      end
   end

   // R1: reset leaves outputs idle.
   a_r1_reset_idle: assert property (@(posedge clk)
      rst |=> (!out_vld && !out_illegal && !out_to_rd && out_data == '0));

   // R8: valid follows the request by one edge.
   a_r8_vld_tracks: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_vld);
   a_r8_vld_idle: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> !out_vld);
   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> ($stable(out_data) && $stable(out_illegal) && $stable(out_to_rd)));

   // R7: unsupported code gives a zero result and the flag.
   a_r7_illegal_zero: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> out_data == '0);
   a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
      (in_vld && op == 2'b11) |=> out_illegal);

   // R9: shuffle destination only for the two shuffle codes.
   a_r9_dest: assert property (@(posedge clk) disable iff (rst)
      (in_vld && (op == 2'b01 || op == 2'b10)) |=> (out_to_rd && !out_illegal));
   a_r9_field_dest: assert property (@(posedge clk) disable iff (rst)
      (in_vld && (op == 2'b00 || op == 2'b11)) |=> !out_to_rd);
endmodule

// File: tb/tb_fxu_unit.sv
module tb_fxu_unit;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_vld = 1'b0;
   logic [1:0]    op = 2'b00;
   logic [W-1:0]  src_a = '0;
   logic [W-1:0]  src_b = '0;
   logic [4:0]    lsb_pos = '0;
   logic [4:0]    size_m1 = '0;
   logic [1:0]    byte_pos = '0;
   logic          out_vld;
   logic [W-1:0]  out_data;
   logic          out_illegal;
   logic          out_to_rd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   fxu_unit #(.DATA_W(W), .FUNNEL_IMPL(1'b0)) dut (
      .clk(clk), .rst(rst), .in_vld(in_vld), .op(op),
      .src_a(src_a), .src_b(src_b), .lsb_pos(lsb_pos), .size_m1(size_m1),
      .byte_pos(byte_pos), .out_vld(out_vld), .out_data(out_data),
      .out_illegal(out_illegal), .out_to_rd(out_to_rd)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive at a falling edge, then sample at the next falling edge.
   task automatic issue(logic [1:0] o, logic [W-1:0] a, logic [W-1:0] b,
                        int lsb, int sm, int bp);
      op = o; src_a = a; src_b = b;
      lsb_pos = 5'(lsb); size_m1 = 5'(sm); byte_pos = 2'(bp);
      in_vld = 1'b1;
      @(negedge clk);
      in_vld = 1'b0;
   endtask

   function automatic logic [W-1:0] exp_extract(logic [W-1:0] a, int lsb, int sm);
      longint unsigned m = (64'd1 << (sm + 1)) - 64'd1;
      longint unsigned v = 64'(a) / (64'd1 << lsb);
      return W'(v & m);
   endfunction

   function automatic logic [W-1:0] exp_mirror(logic [W-1:0] b);
      logic [W-1:0] r = '0;
      for (int k = 0; k < 4; k++)
         for (int j = 0; j < 8; j++)
            r[8*k + j] = b[8*k + 7 - j];
      return r;
   endfunction

   function automatic logic [W-1:0] exp_align(logic [W-1:0] a, logic [W-1:0] b, int bp);
      longint unsigned up = 64'(b) * (64'd1 << (8 * bp));
      longint unsigned dn = (bp == 0) ? 64'd0 : 64'(a) / (64'd1 << (8 * (4 - bp)));
      return W'(up) | W'(dn);
   endfunction

   initial begin
      logic [W-1:0] pats [2];
      logic [W-1:0] saved;
      pats[0] = 32'hFFFF_FFFF;
      pats[1] = 32'hA5C3_1E69;

      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 vld", W'(out_vld), '0);
      check("R1 illegal", W'(out_illegal), '0);
      check("R1 to_rd", W'(out_to_rd), '0);
      check("R1 data", out_data, '0);
      rst = 1'b0;
      @(negedge clk);

      // R2/R3: every start position against every size
      for (int p = 0; p < 2; p++)
         for (int lsb = 0; lsb < 32; lsb++)
            for (int sm = 0; sm < 32; sm++) begin
               issue(2'b00, pats[p], ~pats[p], lsb, sm, 0);
               if (lsb + sm + 1 > 32)
                  check("R3 extract overflow", out_data, exp_extract(pats[p], lsb, sm));
               else
                  check("R2 extract", out_data, exp_extract(pats[p], lsb, sm));
               check("R9 extract dest", W'(out_to_rd), '0);
               check("R8 vld", W'(out_vld), 1);
            end

      // R4: every byte value in each lane
      for (int v = 0; v < 256; v++) begin
         logic [W-1:0] b = {8'(v), 8'(v ^ 8'h5A), 8'(255 - v), 8'(v * 3)};
         issue(2'b01, 32'h1234_5678, b, 0, 0, 0);
         check("R4 mirror", out_data, exp_mirror(b));
         check("R9 mirror dest", W'(out_to_rd), 1);
      end

      // R5/R6: every byte position
      for (int bp = 0; bp < 4; bp++)
         for (int s = 0; s < 6; s++) begin
            logic [W-1:0] a = 32'h0102_0304 * (s + 1) ^ 32'hF0E1_D2C3;
            logic [W-1:0] b = 32'h8899_AABB + 32'(s * 32'h1357_9BDF);
            issue(2'b10, a, b, 0, 0, bp);
            if (bp == 0) check("R5 align zero", out_data, b);
            else         check("R6 align", out_data, exp_align(a, b, bp));
            check("R9 align dest", W'(out_to_rd), 1);
         end

      // R7: unsupported code
      issue(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 7, 2);
      check("R7 zero", out_data, '0);
      check("R7 flag", W'(out_illegal), 1);
      check("R9 illegal dest", W'(out_to_rd), 0);

      // R8: idle cycle holds previous outputs
      issue(2'b01, '0, 32'h0000_0001, 0, 0, 0);
      saved = out_data;
      check("R7 flag clears", W'(out_illegal), 0);
      op = 2'b10; src_a = 32'hDEAD_BEEF; src_b = 32'hCAFE_F00D; byte_pos = 2'd1;
      in_vld = 1'b0;
      @(negedge clk);
      check("R8 idle vld", W'(out_vld), 0);
      check("R8 hold data", out_data, saved);
      check("R8 hold to_rd", W'(out_to_rd), 1);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule